// File: doc/BRIEF.md
# Halt-Aware Watchdog Timer

This block is a watchdog timer for a small microcontroller. It also handles the processor's low-power halt state. Software arms the watchdog and refreshes its 7-bit countdown by writing one control byte. Bit 7 of that byte is the activation flag and bits 6:0 are the new count. Once the flag is set, software cannot clear it; only a system reset clears it. While the watchdog is armed and running, the count falls by one on every clock. A reset request goes out when count bit 6 falls from 1 to 0. That request is held high for a fixed number of cycles so that downstream reset logic can capture it.

A static option input selects what a halt request does while the watchdog is armed. With the option set, the halt raises the reset request at once. With the option clear, the halt freezes the count, and no reset request can occur while halted. Only an external wake interrupt or a system reset ends the halt. After a wake, the count stays frozen for a settling window of 4096 clocks and only then resumes. A halt while the watchdog is disarmed only records the halted state.

The control is a five-state machine:
- `ST_IDLE`: disarmed.
- `ST_DOZE`: disarmed and halted.
- `ST_RUN`: armed and counting.
- `ST_HALT`: armed, halted and frozen.
- `ST_SETTLE`: armed, in the wake settling window.

Its transitions are:
- IDLE→DOZE on a halt request.
- IDLE→RUN on a write with bit 7 set.
- DOZE→IDLE on a wake.
- RUN→HALT on a halt request with the option clear.
- HALT→SETTLE on a wake.
- SETTLE→HALT on a halt request with the option clear.
- SETTLE→RUN when the window ends.
- Any state→IDLE on system reset.

Top module: `halt_aware_watchdog`

## Requirements
- R1: After system reset, the readback `ctrl_rd_o` is 0x7F (activation bit 7 = 0, count = 0x7F) and `wdg_rst_o` is low.
- R2: A write accepted in IDLE, RUN or SETTLE loads `wr_data[6:0]` into the count at the next edge. `wr_data[7]`=1 sets the activation bit. A write with bit 7 = 0 never clears an activation bit that is already set.
- R3: While armed in RUN, the count decreases by exactly one per clock edge.
- R4: When the count steps from 0x40 to 0x3F, `wdg_rst_o` rises at that same edge and stays high for exactly 16 cycles.
- R5: With `halt_rst_opt`=1, a halt request while armed raises `wdg_rst_o` at the next edge for 16 cycles, and counting continues.
- R6: With `halt_rst_opt`=0, a halt request while armed freezes the count at that edge. While halted, the count stays fixed, `wdg_rst_o` stays low, and further writes and halt requests are ignored.
- R7: After a wake interrupt ends an armed halt, the count is unchanged for 4096 edges after the edge that samples the wake, and it decreases at the 4097th edge.
- R8: A write during the settling window reloads the count, but counting still starts only when the window ends.
- R9: A halt while disarmed never raises `wdg_rst_o`. Writes while in that state are ignored. After the wake, an arming write starts counting on the very next edge, with no settling delay.
- R10: A system reset at any time clears the activation bit, returns the count to 0x7F and drops `wdg_rst_o` at once, even in the middle of a reset pulse.
- R11: A write with bit 7 = 0 while disarmed loads the count but does not start counting.
- R12: A write in the same cycle as a halt request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| halt_rst_opt | input | 1 | Static halt policy: 1 = a halt while armed forces a reset, 0 = a halt freezes the watchdog |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Bit 7 = activation flag, bits 6:0 = count to load |
| halt_req | input | 1 | Halt request strobe from the core |
| wake_irq | input | 1 | External wake interrupt |
| wdg_rst_o | output | 1 | Stretched watchdog reset request |
| ctrl_rd_o | output | 8 | Registered readback: activation bit and count |

## Verification
Every result here is one register stage away from the stimulus that causes it:
- A write shows in the readback at the next edge.
- Each armed edge takes one count off.
- The reset request rises at the edge that moves the count from 0x40 to 0x3F, or at the edge after an option-set halt. It then lasts 16 samples.

The bench drives inputs on the falling edge and samples after the next falling edge. After a wake, it counts edges explicitly: the readback must be unchanged after edge 4096 and one lower after edge 4097. Randomised refresh values get their expected readback and firing edge from bench functions of the loaded value and the elapsed edges.

// File: rtl/hawd_pkg.sv
package hawd_pkg;

    // Controller states of the halt-aware watchdog
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // disarmed
        ST_DOZE   = 3'd1,   // disarmed and halted
        ST_RUN    = 3'd2,   // armed, counting
        ST_HALT   = 3'd3,   // armed, halted, frozen
        ST_SETTLE = 3'd4    // armed, post-wake settling window
    } wd_state_e;

endpackage

// File: rtl/hawd_count.sv
module hawd_count #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] RST_VAL   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EXPIRE_AT = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // top bit falls on the step that leaves EXPIRE_AT
    assign expire_o = dec && !load && (cnt_q == EXPIRE_AT);
    assign cnt_o    = cnt_q;

    // R3: one decrement per enabled edge
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: a load lands on the next edge
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/hawd_settle.sv
module hawd_settle #(
    parameter int SETTLE_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    output logic done_o
);

    localparam int             SW   = $clog2(SETTLE_CYC);
    localparam logic [SW-1:0]  LAST = SW'(SETTLE_CYC - 1);

    logic [SW-1:0] scnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
        end else if (start) begin
            scnt_q <= LAST;
        end else if (en && (scnt_q != '0)) begin
            scnt_q <= scnt_q - 1'b1;
        end
    end

    assign done_o = en && (scnt_q == '0);

    // R7: the window can never end on the edge right after it opens
    a_r7_no_instant_end: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_o);

endmodule

// File: rtl/hawd_stretch.sv
module hawd_stretch #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic hold_o
);

    localparam int            HW   = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_CYC);

    logic [HW-1:0] hcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
        end else if (trig) begin
            hcnt_q <= FULL;
        end else if (hcnt_q != '0) begin
            hcnt_q <= hcnt_q - 1'b1;
        end
    end

    assign hold_o = (hcnt_q != '0);

    // R4: a trigger always yields a pulse on the following cycle
    a_r4_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> hold_o);

    // R4: once started, the pulse is held (no single-cycle glitch)
    a_r4_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |=> hold_o);

endmodule

// File: rtl/halt_aware_watchdog.sv
module halt_aware_watchdog
    import hawd_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int SETTLE_CYC = 4096,
    parameter int HOLD_CYC   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt_rst_opt,
    input  logic           wr_en,
    input  logic [CNT_W:0] wr_data,
    input  logic           halt_req,
    input  logic           wake_irq,
    output logic           wdg_rst_o,
    output logic [CNT_W:0] ctrl_rd_o
);

    wd_state_e        state_q, state_d;
    logic             wr_ok;
    logic             arm_bit;
    logic             cnt_load, cnt_dec, expire;
    logic [CNT_W-1:0] cnt;
    logic             settle_start, settle_en, settle_done;
    logic             halt_fire, fire;
    logic             armed;

    assign arm_bit = wr_data[CNT_W];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (halt_req) begin
                    state_d = ST_DOZE;
                end else if (wr_en && arm_bit) begin
                    state_d = ST_RUN;
                end
            end
            ST_DOZE: begin
                if (wake_irq) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (halt_req && !halt_rst_opt) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (wake_irq) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (halt_req && !halt_rst_opt) begin
                    state_d = ST_HALT;
                end else if (settle_done) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- output / datapath control ----------------
    always_comb begin
        wr_ok        = 1'b0;
        cnt_dec      = 1'b0;
        settle_start = 1'b0;
        settle_en    = 1'b0;
        halt_fire    = 1'b0;
        armed        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_ok = wr_en && !halt_req;
            end
            ST_DOZE: begin
                wr_ok = 1'b0;
            end
            ST_RUN: begin
                armed     = 1'b1;
                wr_ok     = wr_en && !halt_req;
                halt_fire = halt_req && halt_rst_opt;
                cnt_dec   = !wr_ok && !(halt_req && !halt_rst_opt);
            end
            ST_HALT: begin
                armed        = 1'b1;
                settle_start = wake_irq;
            end
            ST_SETTLE: begin
                armed     = 1'b1;
                wr_ok     = wr_en && !halt_req;
                halt_fire = halt_req && halt_rst_opt;
                settle_en = 1'b1;
            end
            default: begin
                wr_ok = 1'b0;
            end
        endcase
    end

    assign cnt_load = wr_ok;
    assign fire     = expire || halt_fire;

    hawd_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data[CNT_W-1:0]),
        .dec      (cnt_dec),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    hawd_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (settle_start),
        .en     (settle_en),
        .done_o (settle_done)
    );

    hawd_stretch #(
        .HOLD_CYC (HOLD_CYC)
    ) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (fire),
        .hold_o (wdg_rst_o)
    );

    assign ctrl_rd_o = {armed, cnt};

    // ---------------- assertions ----------------
    // R6: count is frozen while halted
    a_r6_frozen_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> $stable(cnt));

    // R6: no reset trigger while halted
    a_r6_quiet_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !fire);

    // R8: no decrement during the settling window without a write
    a_r8_settle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !wr_en) |=> $stable(cnt));

    // R2: activation is sticky until system reset
    a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> ctrl_rd_o[CNT_W]);

    // R5: halt with the reset option while running raises the request
    a_r5_halt_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && halt_rst_opt && state_q == ST_RUN) |=> wdg_rst_o);

    // R9: a disarmed halt never triggers a reset
    a_r9_doze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE) |-> !fire);

    // R12: a write alongside a halt request never reaches the counter
    a_r12_halt_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && wr_en && state_q != ST_RUN && state_q != ST_SETTLE) |=> $stable(cnt));

endmodule

// File: tb/halt_aware_watchdog_test.sv
module halt_aware_watchdog_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       halt_rst_opt;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       halt_req;
    logic       wake_irq;
    logic       wdg_rst_o;
    logic [7:0] ctrl_rd_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    halt_aware_watchdog uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_rst_opt (halt_rst_opt),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .halt_req     (halt_req),
        .wake_irq     (wake_irq),
        .wdg_rst_o    (wdg_rst_o),
        .ctrl_rd_o    (ctrl_rd_o)
    );

    // expected readback: activation bit over 7-bit count
    function automatic logic [7:0] exp_rd(bit act, int cnt);
        logic [6:0] c;
        c = cnt[6:0];
        return {act, c};
    endfunction

    // edges after a load until the 0x40 -> 0x3F step
    function automatic int fire_gap(int v);
        return v - 'h3F;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic halt_pulse();
        halt_req = 1'b1;
        step(1);
        halt_req = 1'b0;
    endtask

    task automatic wake_pulse();
        wake_irq = 1'b1;
        step(1);
        wake_irq = 1'b0;
    endtask

    task automatic sys_reset(bit opt);
        rst_n = 1'b0;
        halt_rst_opt = opt;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7781));
        rst_n = 1'b0; halt_rst_opt = 1'b0; wr_en = 1'b0; wr_data = '0;
        halt_req = 1'b0; wake_irq = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 readback", ctrl_rd_o, 8'h7F);
        chk("R1 reset req", wdg_rst_o, 1'b0);

        // R11 disarmed load
        wr(8'h35);
        chk("R11 load", ctrl_rd_o, exp_rd(0, 'h35));
        step(5);
        chk("R11 no count", ctrl_rd_o, exp_rd(0, 'h35));

        // R12 write with halt dropped; R9 disarmed halt
        halt_req = 1'b1; wr_en = 1'b1; wr_data = 8'hF0;
        step(1);
        halt_req = 1'b0; wr_en = 1'b0;
        chk("R12 write dropped", ctrl_rd_o, exp_rd(0, 'h35));
        wr(8'hF0);
        chk("R9 write ignored", ctrl_rd_o, exp_rd(0, 'h35));
        step(50);
        chk("R9 no reset", wdg_rst_o, 1'b0);
        wake_pulse();
        wr(8'hF0);
        chk("R9 armed", ctrl_rd_o, exp_rd(1, 'h70));
        step(1);
        chk("R9 no delay", ctrl_rd_o, exp_rd(1, 'h6F));

        // R3 steady countdown
        step(10);
        chk("R3 countdown", ctrl_rd_o, exp_rd(1, 'h65));

        // R2 write without arm bit keeps activation
        wr(8'h7A);
        chk("R2 sticky", ctrl_rd_o, exp_rd(1, 'h7A));
        step(1);
        chk("R2 still counting", ctrl_rd_o, exp_rd(1, 'h79));

        // R4 expiry
        wr(8'hC5);
        step(fire_gap('h45) - 1);
        chk("R4 before", ctrl_rd_o, exp_rd(1, 'h40));
        chk("R4 low before", wdg_rst_o, 1'b0);
        step(1);
        chk("R4 count", ctrl_rd_o, exp_rd(1, 'h3F));
        chk("R4 fired", wdg_rst_o, 1'b1);
        step(15);
        chk("R4 held", wdg_rst_o, 1'b1);
        step(1);
        chk("R4 released", wdg_rst_o, 1'b0);

        // R6 halt freezes
        wr(8'hFF);
        step(3);
        chk("R6 pre", ctrl_rd_o, exp_rd(1, 'h7C));
        halt_pulse();
        chk("R6 frozen", ctrl_rd_o, exp_rd(1, 'h7C));
        step(300);
        chk("R6 still frozen", ctrl_rd_o, exp_rd(1, 'h7C));
        chk("R6 no reset", wdg_rst_o, 1'b0);
        wr(8'h90);
        chk("R6 write ignored", ctrl_rd_o, exp_rd(1, 'h7C));
        halt_pulse();
        chk("R6 halt ignored", ctrl_rd_o, exp_rd(1, 'h7C));

        // R7 settle window
        wake_pulse();
        step(4095);
        chk("R7 mid window", ctrl_rd_o, exp_rd(1, 'h7C));
        step(1);
        chk("R7 edge 4096", ctrl_rd_o, exp_rd(1, 'h7C));
        step(1);
        chk("R7 resumes", ctrl_rd_o, exp_rd(1, 'h7B));

        // R8 refresh inside window
        halt_pulse();
        chk("R8 halted", ctrl_rd_o, exp_rd(1, 'h7B));
        wake_pulse();
        step(100);
        wr(8'hE0);
        chk("R8 reload", ctrl_rd_o, exp_rd(1, 'h60));
        step(4096 - 101);
        chk("R8 held", ctrl_rd_o, exp_rd(1, 'h60));
        step(1);
        chk("R8 resumes", ctrl_rd_o, exp_rd(1, 'h5F));

        // R10 reset mid-pulse
        wr(8'hC2);
        step(fire_gap('h42));
        chk("R10 pulse up", wdg_rst_o, 1'b1);
        step(3);
        rst_n = 1'b0;
        #1;
        chk("R10 req drops", wdg_rst_o, 1'b0);
        chk("R10 readback", ctrl_rd_o, 8'h7F);
        halt_rst_opt = 1'b1;
        step(1);
        rst_n = 1'b1;
        step(5);
        chk("R10 stays idle", ctrl_rd_o, 8'h7F);

        // R9 disarmed halt with reset option
        halt_pulse();
        chk("R9 opt no reset", wdg_rst_o, 1'b0);
        wake_pulse();

        // R5 halt forces reset
        wr(8'hFF);
        halt_pulse();
        chk("R5 fired", wdg_rst_o, 1'b1);
        chk("R5 counts on", ctrl_rd_o, exp_rd(1, 'h7E));
        step(15);
        chk("R5 held", wdg_rst_o, 1'b1);
        step(1);
        chk("R5 released", wdg_rst_o, 1'b0);

        // random refresh / countdown (R3, R4)
        sys_reset(1'b0);
        for (int i = 0; i < 16; i++) begin
            int v;
            int k;
            v = 'h48 + int'($urandom_range(0, 'h37));
            wr({1'b1, v[6:0]});
            k = int'($urandom_range(0, v - 'h41));
            step(k);
            chk("R3 random count", ctrl_rd_o, exp_rd(1, v - k));
            chk("R3 random quiet", wdg_rst_o, 1'b0);
            if (i % 4 == 0) begin
                step(fire_gap(v) - k);
                chk("R4 random fire", wdg_rst_o, 1'b1);
                step(16);
                chk("R4 random end", wdg_rst_o, 1'b0);
            end
        end

        summary();
        $finish;
    end

endmodule